// File: doc/BRIEF.md
# Video Filter Input Conditioning Unit

This block prepares the sample stream for a 2:1 decimating or interpolating video filter core. It registers a 12-bit input word every clock. It turns unsigned video words into signed values and, in interpolate mode, loads real samples only on the clocks the timing controller marks. On the other clocks it feeds zeros, so the core sees a stream at the full output rate.

Serial digital video carries timing reference words inside the data. A timing reference is a run of one all-ones word and two all-zero words, judged on the upper ten bits. If such a run reached the filter it would produce large transients. The block holds real samples in a short look-ahead window. When a run is found, each of its three words is replaced by the last sample that passed unmasked. The filter core then sees a flat signal across the reference instead of a spike.

Top module: `vid_in_cond`

## Requirements
- R1: When `rst` is high at a rising clock edge, `dout` is 0 after that edge. The look-ahead words and the held sample are cleared to zero.
- R2: With `interp`=0, a word on `din` at edge k appears on `dout` after edge k+4, and a new word is taken on every clock.
- R3: With `fmt_uns`=1, the output word equals the input word with bit 11 inverted, which maps unsigned mid-scale 0x800 to signed zero. With `fmt_uns`=0, the word passes unchanged.
- R4: With `interp`=1 and `phase`=0 at edge k, `dout` is 0 after edge k+1, and the value on `din` at that edge is discarded.
- R5: With `interp`=1, only words presented with `phase`=1 are loaded. Each one emerges at the fourth later load, so with `phase` alternating 1,0,1,0 a word appears 7 clocks after it was presented.
- R6: Three consecutively loaded words whose bits 11:2 equal 0x3FF, 0x000 and 0x000 are each replaced on `dout` by the held sample. Bits 1:0 take no part in the match. This applies in both formats.
- R7: The held sample is the converted value of the most recent unmasked word that left the window. It is zero after reset.
- R8: An all-ones word followed by fewer than two all-zero words (bits 11:2) passes unmasked.
- R9: The word that follows the two all-zero words of a reference run passes unmasked.
- R10: In interpolate mode, the zero slots and whatever `din` carries during them neither break a reference run of loaded words nor form one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 12 | Input video word, bit 11 is the MSB |
| fmt_uns | input | 1 | 1 = unsigned input format, 0 = two's complement |
| interp | input | 1 | 1 = interpolate (zero stuffing), 0 = decimate (load every clock) |
| phase | input | 1 | In interpolate mode, 1 marks a real-sample clock and 0 a zero slot |
| dout | output | 12 | Signed conditioned sample for the filter core |

## Verification
The hardest case to reach from the ports is a reference run spread over interpolate mode. Here the three loaded words sit on alternate clocks, and junk words, including all-ones and all-zero codes, sit on the discarded zero slots between them. The stimulus drives exactly this pattern, irregular phase spacing, and runs next to near-miss patterns (one zero only, or a non-zero second word). It also switches format while a held sample is live. A behavioural model keeps every loaded word in a list and decides masking by index arithmetic.

// File: rtl/vfic_pkg.sv
package vfic_pkg;
  // Length of a timing reference run (ones word then two zero words)
  localparam int unsigned TRS_RUN = 3;

  typedef struct packed {
    logic ld;       // this clock loads a real sample
    logic fmt_uns;  // unsigned input format
  } vfic_ctl_t;
endpackage

// File: rtl/vfic_in_reg.sv
module vfic_in_reg
  import vfic_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              fmt_uns,
  input  logic              interp,
  input  logic              phase,
  output logic [DATA_W-1:0] word_q,
  output vfic_ctl_t         ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      ctl_q  <= '0;
    end else begin
      word_q       <= din;
      ctl_q.ld     <= !interp || phase;
      ctl_q.fmt_uns <= fmt_uns;
    end
  end
endmodule

// File: rtl/vfic_trs_window.sv
module vfic_trs_window
  import vfic_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] leave_word,
  output logic              leave_flag
);
  localparam int unsigned DEPTH = TRS_RUN;
  localparam int unsigned CODE_LSB = DATA_W - CODE_W;
  localparam int unsigned NZ = DEPTH - 1;

  logic [DATA_W-1:0] stage_w [DEPTH];
  logic [DEPTH-1:0]  stage_f;
  logic [NZ-1:0]     zero_hit;
  logic              ones_hit;
  logic              run_det;

  // Zero-word checks: incoming word plus the younger window stages
  for (genvar i = 0; i < NZ; i++) begin : g_zero
    if (i == 0) begin : g_in
      assign zero_hit[i] = (word_in[DATA_W-1:CODE_LSB] == '0);
    end else begin : g_st
      assign zero_hit[i] = (stage_w[i-1][DATA_W-1:CODE_LSB] == '0);
    end
  end

  assign ones_hit = (stage_w[DEPTH-2][DATA_W-1:CODE_LSB] == '1);
  assign run_det  = ones_hit && (&zero_hit);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_w[i] <= '0;
      end else if (ld) begin
        if (i == 0) stage_w[i] <= word_in;
        else        stage_w[i] <= stage_w[(i == 0) ? 0 : i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_f <= '0;
    end else if (ld) begin
      if (run_det) stage_f <= '1;
      else         stage_f <= {stage_f[DEPTH-2:0], 1'b0};
    end
  end

  assign leave_word = stage_w[DEPTH-1];
  assign leave_flag = stage_f[DEPTH-1];

  // R6
  trs_run_whole_chk: assert property (@(posedge clk) disable iff (rst)
    stage_f[0] |-> (&stage_f));
endmodule

// File: rtl/vfic_out_stage.sv
module vfic_out_stage #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              fmt_uns,
  input  logic [DATA_W-1:0] leave_word,
  input  logic              leave_flag,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] conv_word;
  logic [DATA_W-1:0] held_q;

  // Unsigned to signed: flip the MSB (subtract half scale)
  assign conv_word = {leave_word[DATA_W-1] ^ fmt_uns, leave_word[DATA_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      held_q <= '0;
    end else if (ld) begin
      if (leave_flag) begin
        dout <= held_q;
      end else begin
        dout   <= conv_word;
        held_q <= conv_word;
      end
    end else begin
      dout <= '0;
    end
  end

  // R6
  masked_uses_held_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && leave_flag) |=> (dout == $past(held_q)));

  // R7
  held_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    !(ld && !leave_flag) |=> $stable(held_q));
endmodule

// File: rtl/vid_in_cond.sv
module vid_in_cond
  import vfic_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              fmt_uns,
  input  logic              interp,
  input  logic              phase,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] word_q;
  vfic_ctl_t         ctl_q;
  logic [DATA_W-1:0] leave_word;
  logic              leave_flag;

  vfic_in_reg #(.DATA_W(DATA_W)) in_reg_i (
    .clk(clk), .rst(rst), .din(din), .fmt_uns(fmt_uns),
    .interp(interp), .phase(phase), .word_q(word_q), .ctl_q(ctl_q)
  );

  vfic_trs_window #(.DATA_W(DATA_W), .CODE_W(CODE_W)) window_i (
    .clk(clk), .rst(rst), .ld(ctl_q.ld), .word_in(word_q),
    .leave_word(leave_word), .leave_flag(leave_flag)
  );

  vfic_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .ld(ctl_q.ld), .fmt_uns(ctl_q.fmt_uns),
    .leave_word(leave_word), .leave_flag(leave_flag), .dout(dout)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dout == '0));

  // R4
  zero_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (interp && !phase) |=> ##1 (dout == '0));
endmodule

// File: tb/vid_in_cond_tb_top.sv
module vid_in_cond_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] din = '0;
  logic        fmt_uns = 1'b0;
  logic        interp = 1'b0;
  logic        phase = 1'b0;
  logic [11:0] dout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  vid_in_cond dut_i (
    .clk(clk), .rst(rst), .din(din), .fmt_uns(fmt_uns),
    .interp(interp), .phase(phase), .dout(dout)
  );

  // Behavioural reference model
  logic [11:0] hist[$];
  logic [11:0] p_word;
  bit          p_ld, p_fmt;
  logic [11:0] held, exp_v;
  string       exp_tag;

  function automatic bit is_ones(logic [11:0] w); return w[11:2] == 10'h3FF; endfunction
  function automatic bit is_zero(logic [11:0] w); return w[11:2] == 10'h000; endfunction
  function automatic bit run_at(int s);
    if (s < 0 || s + 2 >= hist.size()) return 0;
    return is_ones(hist[s]) && is_zero(hist[s+1]) && is_zero(hist[s+2]);
  endfunction

  initial begin
    hist = '{12'h0, 12'h0, 12'h0};
    held = '0; exp_v = '0; exp_tag = "R1";
    p_word = '0; p_ld = 0; p_fmt = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      hist = '{12'h0, 12'h0, 12'h0};
      held = '0; exp_v = '0; exp_tag = "R1";
      p_word = '0; p_ld = 0; p_fmt = 0;
    end else begin
      if (p_ld) begin
        int k;
        logic [11:0] cv;
        hist.push_back(p_word);
        k = hist.size() - 4;
        cv = {hist[k][11] ^ p_fmt, hist[k][10:0]};
        if (run_at(k) || run_at(k-1) || run_at(k-2)) begin
          exp_v = held; exp_tag = "R6 R7";
        end else begin
          exp_v = cv; held = cv; exp_tag = "";
        end
      end else begin
        exp_v = '0; exp_tag = "R4";
      end
      p_word = din; p_ld = !interp || phase; p_fmt = fmt_uns;
    end
  end

  task automatic check_now();
    string t;
    t = (exp_tag == "") ? cur_tag : exp_tag;
    n_chk++;
    if (dout !== exp_v) begin
      n_fail++;
      $display("FAIL %s: dout=%h expected %h at %0t", t, dout, exp_v, $time);
    end
  endtask

  task automatic step(input logic [11:0] d, input logic ph);
    @(negedge clk);
    if (done) return;
    check_now();
    din = d; phase = ph;
  endtask

  logic [15:0] lf = 16'hACE1;
  function automatic logic [15:0] nx(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    // R1: reset state
    cur_tag = "R1";
    for (int i = 0; i < 4; i++) step(12'hABC, 1'b1);
    rst = 1'b0;
    // R2: decimate, signed, varied words
    cur_tag = "R2";
    for (int i = 0; i < 40; i++) begin lf = nx(lf); step(lf[11:0], 1'b0); end
    // R6, R8, R9: runs and near misses in decimate mode
    cur_tag = "R9";
    step(12'h321, 0); step(12'hFFE, 0); step(12'h002, 0); step(12'h001, 0);
    step(12'h5A5, 0); step(12'h5A6, 0);
    cur_tag = "R8";
    step(12'hFFC, 0); step(12'h000, 0); step(12'h010, 0); step(12'h777, 0);
    step(12'hFFF, 0); step(12'h003, 0); step(12'h444, 0); step(12'h000, 0);
    for (int i = 0; i < 5; i++) step(12'h100 + 12'(i), 0);
    // R3, R7: unsigned format with a run
    cur_tag = "R3";
    fmt_uns = 1'b1;
    for (int i = 0; i < 20; i++) begin lf = nx(lf); step(lf[11:0], 1'b0); end
    step(12'h800, 0); step(12'h7FF, 0); step(12'hFFD, 0); step(12'h000, 0);
    step(12'h002, 0); step(12'h900, 0);
    for (int i = 0; i < 5; i++) step(12'h0F0, 0);
    fmt_uns = 1'b0;
    // R5: interpolate, alternating phase
    cur_tag = "R5";
    interp = 1'b1;
    for (int i = 0; i < 30; i++) begin lf = nx(lf); step(lf[11:0], i[0] == 1'b0); end
    // R10: run spread over real slots with junk in zero slots
    cur_tag = "R10";
    step(12'h234, 1); step(12'h000, 0); step(12'hFFF, 1); step(12'hFFF, 0);
    step(12'h001, 1); step(12'hFFC, 0); step(12'h000, 1); step(12'hABC, 0);
    step(12'h456, 1); step(12'h000, 0); step(12'hFFF, 1); step(12'h000, 0);
    step(12'h000, 0); step(12'h000, 1); step(12'h000, 0); step(12'h333, 1);
    for (int i = 0; i < 10; i++) step(12'h055, i[0] == 1'b0);
    // R5: irregular phase spacing
    cur_tag = "R5";
    for (int i = 0; i < 30; i++) begin lf = nx(lf); step(lf[11:0], lf[13]); end
    // R2: back to decimate
    cur_tag = "R2";
    interp = 1'b0;
    for (int i = 0; i < 12; i++) step(12'h600 + 12'(i), 0);
    // R1: reset with live data
    cur_tag = "R1";
    rst = 1'b1;
    step(12'h123, 0); step(12'h123, 0);
    rst = 1'b0;
    cur_tag = "R7";
    for (int i = 0; i < 6; i++) step(12'h000, 0);
    @(negedge clk);
    if (!done) begin
      check_now();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule